// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the media-side engine of a receive ring kept in shared memory. Frames arrive as a byte stream framed by start and end flags. Each accepted frame is written into the buffer tied to the descriptor at the head of the ring. When the last byte lands, that descriptor's ownership flag flips to the processor and its byte count is recorded. A one-cycle receive interrupt is also raised. The controller never waits for the processor to answer. It steps to the next descriptor and goes on receiving.

The processor takes a frame by reading the descriptor and relinking the buffer; the data is never copied. It gives descriptors back in ring order with a single return strobe, which works on a tail index held inside the block. If the head descriptor still belongs to the processor when a new frame starts, the ring is overrun. That frame is dropped whole and a saturating drop counter counts it. Frames longer than one buffer are cut to buffer size, and a truncation flag is set in the descriptor.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every descriptor is controller-owned (`rd_cpu_own`=0) with length 0 and truncation flag 0, `head_idx`=`tail_idx`=0, `rx_irq`=0 and `ovr_count`=0.
- R2: Every stored byte of an accepted frame appears on `wr_data` with `wr_en`=1 in the same cycle as its input beat. The address is `BASE_ADDR + head_idx*BUF_BYTES + n`, where n counts the bytes of the frame from 0.
- R3: On the end beat of an accepted frame, the head descriptor gets `rd_cpu_own`=1 (1 means processor-owned) and a length equal to the number of stored bytes. `rx_irq` is 1 in the single cycle after that beat.
- R4: `head_idx` advances by one after each accepted frame and wraps from DEPTH-1 to 0, with no processor action needed.
- R5: Bytes past the first BUF_BYTES of a frame are not written. That frame's descriptor records length BUF_BYTES and truncation flag 1; shorter frames record flag 0.
- R6: A frame whose start beat finds the head descriptor processor-owned is dropped whole: no writes, no descriptor change, no interrupt, and `head_idx` unchanged.
- R7: `ovr_count` rises by one for each dropped frame and holds at 2^OVRW-1.
- R8: A `ret_valid` pulse while the descriptor at `tail_idx` is processor-owned makes it controller-owned and advances `tail_idx` with wrap. A pulse while that descriptor is controller-owned changes nothing.
- R9: Beats with `in_valid`=1 and no start flag while no frame is open cause no write, and they do not change the descriptors or `head_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | DATAW | Frame byte |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer byte address |
| wr_data | output | DATAW | Buffer write byte |
| ret_valid | input | 1 | Processor returns the tail descriptor |
| rd_idx | input | IW | Descriptor to inspect |
| rd_cpu_own | output | 1 | Ownership of the inspected descriptor (1 = processor) |
| rd_len | output | LENW | Recorded length of the inspected descriptor |
| rd_trunc | output | 1 | Truncation flag of the inspected descriptor |
| rd_base | output | AW | Buffer base address of the inspected descriptor |
| rx_irq | output | 1 | Receive interrupt pulse |
| head_idx | output | IW | Next descriptor to fill |
| tail_idx | output | IW | Next descriptor to be returned |
| ovr_count | output | OVRW | Saturating dropped-frame count |

## Verification
The write strobe, address and data are combinational, so they are due in the same cycle as the input beat. Descriptor fields, `head_idx`, `tail_idx` and `ovr_count` change at the edge that ends the relevant beat or return strobe. `rx_irq` is high for the cycle that follows the end beat. The bench changes inputs just after the rising edge and compares every output against its reference model at the falling edge. The model advances its state at each rising edge from the inputs that were stable across it, so each result is compared in exactly the cycle it is due.

// File: rtl/rx_desc_ring_pkg.sv
package rx_desc_ring_pkg;
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_FILL = 2'd1,
      RX_DROP = 2'd2
   } rx_state_e;
endpackage

// File: rtl/rx_desc_table.sv
module rx_desc_table #(
   parameter int DEPTH = 16,
   parameter int LENW  = 16,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_en,
   input  logic [IW-1:0]    done_idx,
   input  logic [LENW-1:0]  done_len,
   input  logic             done_trunc,
   input  logic             ret_valid,
   input  logic [IW-1:0]    rd_idx,
   output logic [DEPTH-1:0] own_vec,
   output logic             rd_cpu_own,
   output logic [LENW-1:0]  rd_len,
   output logic             rd_trunc,
   output logic [IW-1:0]    tail_idx
);
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   logic [DEPTH-1:0][LENW-1:0] len_all;
   logic [DEPTH-1:0]           trunc_all;
   logic [IW-1:0]              tail_q;
   logic                       ret_ok;

   assign ret_ok = ret_valid && own_vec[tail_q];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic            own_q;
      logic [LENW-1:0] len_q;
      logic            trunc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            own_q   <= 1'b0;
            len_q   <= '0;
            trunc_q <= 1'b0;
         end else if (done_en && done_idx == IW'(e)) begin
            own_q   <= 1'b1;
            len_q   <= done_len;
            trunc_q <= done_trunc;
         end else if (ret_ok && tail_q == IW'(e)) begin
            own_q   <= 1'b0;
         end
      end
      assign own_vec[e]   = own_q;
      assign len_all[e]   = len_q;
      assign trunc_all[e] = trunc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      tail_q <= '0;
      else if (ret_ok) tail_q <= (tail_q == LAST) ? '0 : tail_q + IW'(1);
   end

   always_comb begin
      rd_cpu_own = 1'b0;
      rd_len     = '0;
      rd_trunc   = 1'b0;
      if (32'(rd_idx) < DEPTH) begin
         rd_cpu_own = own_vec[rd_idx];
         rd_len     = len_all[rd_idx];
         rd_trunc   = trunc_all[rd_idx];
      end
   end

   assign tail_idx = tail_q;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_desc_ring_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int BUF_BYTES = 1524,
   parameter int LENW      = 16,
   parameter int AW        = 16,
   parameter int DATAW     = 8,
   parameter int BASE_ADDR = 0,
   parameter int IW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [DATAW-1:0] in_data,
   input  logic [DEPTH-1:0] own_vec,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DATAW-1:0] wr_data,
   output logic             done_en,
   output logic [LENW-1:0]  done_len,
   output logic             done_trunc,
   output logic             drop_pulse,
   output logic [IW-1:0]    head_idx,
   output logic             irq
);
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   rx_state_e       state_q, state_d;
   logic [IW-1:0]   head_q;
   logic [LENW-1:0] cnt_q, cnt_d;
   logic            trunc_q, trunc_d;
   logic            room;
   logic [LENW-1:0] offset;

   assign room   = 32'(cnt_q) < BUF_BYTES;
   assign offset = (state_q == RX_FILL) ? cnt_q : '0;

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      trunc_d    = trunc_q;
      wr_en      = 1'b0;
      done_en    = 1'b0;
      done_len   = '0;
      done_trunc = 1'b0;
      drop_pulse = 1'b0;
      unique case (state_q)
         RX_IDLE: if (in_valid && in_sop) begin
            if (!own_vec[head_q]) begin
               wr_en   = 1'b1;
               cnt_d   = LENW'(1);
               trunc_d = 1'b0;
               if (in_eop) begin
                  done_en  = 1'b1;
                  done_len = LENW'(1);
               end else begin
                  state_d = RX_FILL;
               end
            end else begin
               drop_pulse = 1'b1;
               if (!in_eop) state_d = RX_DROP;
            end
         end
         RX_FILL: if (in_valid) begin
            wr_en   = room;
            cnt_d   = cnt_q + LENW'(room);
            trunc_d = trunc_q | !room;
            if (in_eop) begin
               done_en    = 1'b1;
               done_len   = cnt_d;
               done_trunc = trunc_d;
               state_d    = RX_IDLE;
            end
         end
         RX_DROP: if (in_valid && in_eop) state_d = RX_IDLE;
         default: state_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         head_q  <= '0;
         cnt_q   <= '0;
         trunc_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         trunc_q <= trunc_d;
         irq     <= done_en;
         if (done_en) head_q <= (head_q == LAST) ? '0 : head_q + IW'(1);
      end
   end

   assign wr_addr  = AW'(BASE_ADDR + 32'(head_q) * BUF_BYTES + 32'(offset));
   assign wr_data  = in_data;
   assign head_idx = head_q;
endmodule

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)                    count <= '0;
      else if (inc && count != TOP)  count <= count + W'(1);
   end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
   parameter int DEPTH     = 16,
   parameter int BUF_BYTES = 1524,
   parameter int LENW      = 16,
   parameter int AW        = 16,
   parameter int DATAW     = 8,
   parameter int OVRW      = 8,
   parameter int BASE_ADDR = 0,
   parameter int IW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [DATAW-1:0] in_data,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DATAW-1:0] wr_data,
   input  logic             ret_valid,
   input  logic [IW-1:0]    rd_idx,
   output logic             rd_cpu_own,
   output logic [LENW-1:0]  rd_len,
   output logic             rd_trunc,
   output logic [AW-1:0]    rd_base,
   output logic             rx_irq,
   output logic [IW-1:0]    head_idx,
   output logic [IW-1:0]    tail_idx,
   output logic [OVRW-1:0]  ovr_count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (BUF_BYTES < 1 || BUF_BYTES >= 2**LENW) begin : g_bad_len
      $error("BUF_BYTES must fit in LENW bits");
   end
   if (BASE_ADDR + DEPTH * BUF_BYTES > 2**AW) begin : g_bad_addr
      $error("ring does not fit in AW address bits");
   end

   logic [DEPTH-1:0] own_vec;
   logic             done_en;
   logic [LENW-1:0]  done_len;
   logic             done_trunc;
   logic             drop_pulse;

   rx_frame_fsm #(
      .DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES), .LENW(LENW), .AW(AW),
      .DATAW(DATAW), .BASE_ADDR(BASE_ADDR), .IW(IW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .own_vec(own_vec),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .done_en(done_en), .done_len(done_len), .done_trunc(done_trunc),
      .drop_pulse(drop_pulse), .head_idx(head_idx), .irq(rx_irq)
   );

   rx_desc_table #(.DEPTH(DEPTH), .LENW(LENW), .IW(IW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .done_en(done_en), .done_idx(head_idx), .done_len(done_len),
      .done_trunc(done_trunc), .ret_valid(ret_valid), .rd_idx(rd_idx),
      .own_vec(own_vec), .rd_cpu_own(rd_cpu_own), .rd_len(rd_len),
      .rd_trunc(rd_trunc), .tail_idx(tail_idx)
   );

   rx_sat_counter #(.W(OVRW)) u_ovr (
      .clk(clk), .rst_n(rst_n), .inc(drop_pulse), .count(ovr_count)
   );

   assign rd_base = (32'(rd_idx) < DEPTH) ? AW'(BASE_ADDR + 32'(rd_idx) * BUF_BYTES) : '0;
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
   parameter int BUF_BYTES = 1524,
   parameter int AW        = 16,
   parameter int OVRW      = 8,
   parameter int BASE_ADDR = 0,
   parameter int IW        = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic            ret_valid,
   input logic            rx_irq,
   input logic [IW-1:0]   head_idx,
   input logic [IW-1:0]   tail_idx,
   input logic [OVRW-1:0] ovr_count
);
   localparam logic [OVRW-1:0] TOP = {OVRW{1'b1}};

   AST_WRITE_IN_HEAD_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((int'(wr_addr) - BASE_ADDR - int'(head_idx) * BUF_BYTES) >= 0 &&
                 (int'(wr_addr) - BASE_ADDR - int'(head_idx) * BUF_BYTES) < BUF_BYTES)); // R5

   AST_IRQ_AFTER_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> head_idx != $past(head_idx)); // R3

   AST_HEAD_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      head_idx != $past(head_idx) |-> rx_irq); // R4

   AST_TAIL_ONLY_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      tail_idx != $past(tail_idx) |-> $past(ret_valid)); // R8

   AST_OVR_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_count == TOP |=> ovr_count == TOP); // R7

   AST_OVR_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovr_count < $past(ovr_count))); // R7
endmodule

bind rx_desc_ring rx_desc_ring_chk #(
   .BUF_BYTES(BUF_BYTES), .AW(AW), .OVRW(OVRW), .BASE_ADDR(BASE_ADDR), .IW(IW)
) u_chk (.*);

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
   localparam int CLK_PERIOD = 10;
   localparam int D  = 16;
   localparam int B  = 1524;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0] in_data = '0;
   logic ret_valid = 1'b0;
   logic [IW-1:0] rd_idx = '0;
   logic wr_en, rd_cpu_own, rd_trunc, rx_irq;
   logic [15:0] wr_addr, rd_base, rd_len;
   logic [7:0] wr_data, ovr_count;
   logic [IW-1:0] head_idx, tail_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_desc_ring u_rx_desc_ring (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ret_valid(ret_valid), .rd_idx(rd_idx),
      .rd_cpu_own(rd_cpu_own), .rd_len(rd_len), .rd_trunc(rd_trunc),
      .rd_base(rd_base), .rx_irq(rx_irq), .head_idx(head_idx),
      .tail_idx(tail_idx), .ovr_count(ovr_count)
   );

   int vectors = 0, errors = 0;
   bit running = 0, rd_auto = 0, done = 0;

   // reference model state
   bit m_own[D]; int m_len[D]; bit m_tr[D];
   int m_head = 0, m_tail = 0, m_state = 0, m_cnt = 0, m_ovr = 0;
   bit m_trc = 0, m_irq = 0;

   task automatic chk(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < D; i++) begin m_own[i] = 0; m_len[i] = 0; m_tr[i] = 0; end
      m_head = 0; m_tail = 0; m_state = 0; m_cnt = 0; m_ovr = 0; m_trc = 0; m_irq = 0;
   endtask

   task automatic complete(int n, bit t);
      m_own[m_head] = 1; m_len[m_head] = n; m_tr[m_head] = t;
      m_head = (m_head + 1) % D; m_irq = 1; m_state = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit tail_cpu;
         tail_cpu = m_own[m_tail];
         m_irq = 0;
         case (m_state)
            0: if (in_valid && in_sop) begin
                  if (!m_own[m_head]) begin
                     if (in_eop) complete(1, 0);
                     else begin m_state = 1; m_cnt = 1; m_trc = 0; end
                  end else begin
                     if (m_ovr < 255) m_ovr++;
                     if (!in_eop) m_state = 2;
                  end
               end
            1: if (in_valid) begin
                  if (m_cnt < B) m_cnt++; else m_trc = 1;
                  if (in_eop) complete(m_cnt, m_trc);
               end
            default: if (in_valid && in_eop) m_state = 0;
         endcase
         if (ret_valid && tail_cpu) begin
            m_own[m_tail] = 0; m_tail = (m_tail + 1) % D;
         end
      end
   end

   // per-cycle comparison against the model, at the falling edge
   always @(negedge clk) begin
      if (running) begin
         bit e_wr;
         e_wr = in_valid && ((m_state == 0 && in_sop && !m_own[m_head]) ||
                             (m_state == 1 && m_cnt < B));
         chk("R2", "wr_en", int'(wr_en), int'(e_wr));
         if (e_wr) begin
            chk("R2", "wr_addr", int'(wr_addr), m_head * B + (m_state == 1 ? m_cnt : 0));
            chk("R2", "wr_data", int'(wr_data), int'(in_data));
         end
         chk("R3", "rx_irq", int'(rx_irq), int'(m_irq));
         chk("R4", "head_idx", int'(head_idx), m_head);
         chk("R8", "tail_idx", int'(tail_idx), m_tail);
         chk("R7", "ovr_count", int'(ovr_count), m_ovr);
         chk("R3", "rd_cpu_own", int'(rd_cpu_own), int'(m_own[rd_idx]));
         chk("R3", "rd_len", int'(rd_len), m_len[rd_idx]);
         chk("R5", "rd_trunc", int'(rd_trunc), int'(m_tr[rd_idx]));
         chk("R2", "rd_base", int'(rd_base), int'(rd_idx) * B);
      end
   end

   always begin
      @(posedge clk); #1;
      if (rd_auto) rd_idx = rd_idx + 4'd1;
   end

   task automatic beat(bit v, bit s, bit e, logic [7:0] d);
      @(posedge clk); #1;
      in_valid = v; in_sop = s; in_eop = e; in_data = d;
   endtask

   task automatic quiet();
      beat(0, 0, 0, 8'h00);
   endtask

   task automatic send_frame(int n, int seed, bit gaps);
      for (int k = 0; k < n; k++) begin
         if (gaps && k % 3 == 2) beat(0, 0, 0, 8'hEE);
         beat(1, k == 0, k == n - 1, 8'((seed + k) & 8'hFF));
      end
      quiet();
   endtask

   task automatic give_back(int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1; ret_valid = 1;
      end
      @(posedge clk); #1; ret_valid = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      running = 1;
      // R1: reset state of every descriptor
      for (int i = 0; i < D; i++) begin
         rd_idx = 4'(i);
         @(negedge clk);
         chk("R1", "own after reset", int'(rd_cpu_own), 0);
         chk("R1", "len after reset", int'(rd_len), 0);
         chk("R1", "trunc after reset", int'(rd_trunc), 0);
      end
      chk("R1", "head after reset", int'(head_idx), 0);
      chk("R1", "tail after reset", int'(tail_idx), 0);
      chk("R1", "ovr after reset", int'(ovr_count), 0);
      rd_auto = 1;

      // R2 R3: short, single-beat and gapped frames
      send_frame(1, 8'h10, 0);
      send_frame(5, 8'h20, 0);
      send_frame(60, 8'h30, 1);
      give_back(2);

      // R4 R6: fill the ring past its end without returns
      for (int f = 0; f < 20; f++) send_frame(3, f, 0);
      begin
         int h0;
         h0 = int'(head_idx);
         send_frame(4, 8'h77, 0);
         @(negedge clk);
         chk("R6", "head after dropped frame", int'(head_idx), h0);
         chk("R6", "irq after dropped frame", int'(rx_irq), 0);
      end

      // R7: saturate the drop counter with single-beat frames
      for (int k = 0; k < 300; k++) beat(1, 1, 1, 8'h55);
      quiet();
      @(negedge clk);
      chk("R7", "ovr saturated", int'(ovr_count), 255);

      // R8: return everything, then one return too many
      give_back(16);
      begin
         int t0;
         t0 = int'(tail_idx);
         give_back(1);
         @(negedge clk);
         chk("R8", "tail after ignored return", int'(tail_idx), t0);
      end

      // R9: stray beats outside a frame
      begin
         int h1;
         h1 = int'(head_idx);
         beat(1, 0, 0, 8'hA5);
         @(negedge clk);
         chk("R9", "no write on stray beat", int'(wr_en), 0);
         beat(1, 0, 1, 8'h5A);
         quiet();
         @(negedge clk);
         chk("R9", "head after stray beats", int'(head_idx), h1);
      end

      // R5: oversize frame is cut to buffer size
      begin
         int hl;
         hl = int'(head_idx);
         send_frame(B + 6, 8'h01, 0);
         rd_auto = 0;
         rd_idx = 4'(hl);
         @(negedge clk);
         chk("R5", "len of oversize frame", int'(rd_len), B);
         chk("R5", "trunc of oversize frame", int'(rd_trunc), 1);
         rd_auto = 1;
      end

      // exact-size frame, then more frames with returns across the wrap
      send_frame(B, 8'h02, 0);
      for (int f = 0; f < 18; f++) begin
         send_frame(2 + f % 4, 8'h40 + f, f % 2 == 1);
         give_back(1);
      end
      repeat (4) @(posedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule